// File: doc/BRIEF.md
# Set/Way Cache Clean Controller

This controller carries out one clean-by-set/way maintenance request on a single configured cache level. It takes a 64-bit operand along with the requester's privilege level and the hypervisor trap controls. It first decides whether the request traps to the hypervisor or is undefined. If neither applies, it pulls the level, set and way out of the operand, using positions that follow the cache geometry.

For a line that is in range, the controller reads the tag and state through an array port that answers in the same cycle. If the line is valid and dirty, it sends a write-back request with a valid/ready handshake and then tells the array to clear the dirty bit. Every request ends with a single-cycle `done` pulse. Trap and undefined results are reported alongside that pulse. A request whose level, set or way is out of range completes with no line touched.

Top module: `swclean_ctrl`

## Requirements
- R1: Operand bits [63:32], bit [0], bits [L-1:4] and the bits between the set field and the way field have no effect on the line selected or on the outcome.
- R2: Operand bits [3:1] hold the target cache level minus one. Only the value `LEVEL_IMPL` is served. Any other value completes with `done`, with no array access and no trap.
- R3: With A = ceil(log2(WAYS)), L = log2(LINE_BYTES) and S = ceil(log2(SETS)), the way index is taken from operand bits [31:32-A] and the set index from bits [L+S-1:L]. These values are presented on `arr_way` and `arr_set` while `arr_rd_en` is high.
- R4: A way index of WAYS or more, or a set index of SETS or more, completes with `done`, with no array read, no write-back and no trap.
- R5: At privilege level 1, with `el2_enabled` and `hyp_sw_trap` both 1, the request ends with `res_trap` high and `res_ec` = 0x18, and the array is not accessed. With `el2_enabled` at 0 there is no trap.
- R6: At privilege level 1, with `el2_enabled` and `hyp_fg_trap` both 1, the request traps with class 0x18 when `el3_present` is 0 or `mon_fgt_en` is 1. Otherwise it proceeds normally.
- R7: At privilege level 0, the request ends with `res_undef` high and no array access. At privilege levels 2 and 3, the trap inputs are ignored.
- R8: A valid, dirty line produces `wb_valid` with `wb_addr` = {tag, set, L zero bits}. This stays held until `wb_ready` is seen. Exactly one `arr_clr_dirty` cycle follows, and then `done`.
- R9: A line that is clean or invalid produces one read, no write-back and no dirty clear before `done`.
- R10: `busy` is high from the cycle after acceptance through the `done` cycle. Requests that arrive while busy are ignored. `done` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_operand | input | 64 | Set/way maintenance operand |
| req_el | input | 2 | Privilege level of the requester |
| el2_enabled | input | 1 | Hypervisor level is enabled |
| el3_present | input | 1 | Secure monitor level exists |
| hyp_sw_trap | input | 1 | Hypervisor set/way trap control |
| hyp_fg_trap | input | 1 | Fine-grained clean-by-set/way trap control |
| mon_fgt_en | input | 1 | Monitor fine-grained-trap enable |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| res_trap | output | 1 | Request trapped to the hypervisor (valid with done) |
| res_undef | output | 1 | Request undefined (valid with done) |
| res_ec | output | 6 | Exception class, 0x18 on trap, else 0 |
| arr_rd_en | output | 1 | Array read strobe |
| arr_set | output | S | Set index for the array |
| arr_way | output | A | Way index for the array |
| arr_rd_tag | input | TAG_W | Tag read from the array, same cycle |
| arr_rd_valid | input | 1 | Line valid bit, same cycle |
| arr_rd_dirty | input | 1 | Line dirty bit, same cycle |
| arr_clr_dirty | output | 1 | Clear dirty bit of arr_set/arr_way |
| wb_valid | output | 1 | Write-back request valid |
| wb_addr | output | TAG_W+S+L | Line address for write-back |
| wb_ready | input | 1 | Write-back request accepted |

## Verification
The assertions assume that the array returns tag and state combinationally in the same cycle as `arr_rd_en`. They also assume that `wb_ready` is sampled only while `wb_valid` is high. The bench models the array as a combinational lookup and holds `wb_ready` at 0 except during write-back cycles. While a request is in flight, the bench deliberately toggles `req_valid` and drives random operands, so that the busy-ignore property is exercised rather than assumed.

// File: rtl/swclean_ctrl.sv
module swclean_ctrl #(
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 128,
  parameter int TAG_W      = 24,
  parameter int LEVEL_IMPL = 0,
  localparam int A  = $clog2(WAYS),
  localparam int L  = $clog2(LINE_BYTES),
  localparam int S  = $clog2(SETS),
  localparam int AW = TAG_W + S + L
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [63:0]      req_operand,
  input  logic [1:0]       req_el,
  input  logic             el2_enabled,
  input  logic             el3_present,
  input  logic             hyp_sw_trap,
  input  logic             hyp_fg_trap,
  input  logic             mon_fgt_en,
  output logic             busy,
  output logic             done,
  output logic             res_trap,
  output logic             res_undef,
  output logic [5:0]       res_ec,
  output logic             arr_rd_en,
  output logic [S-1:0]     arr_set,
  output logic [A-1:0]     arr_way,
  input  logic [TAG_W-1:0] arr_rd_tag,
  input  logic             arr_rd_valid,
  input  logic             arr_rd_dirty,
  output logic             arr_clr_dirty,
  output logic             wb_valid,
  output logic [AW-1:0]    wb_addr,
  input  logic             wb_ready
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECODE, ST_READ, ST_WB, ST_UPD, ST_DONE
  } state_t;

  state_t           st;
  logic [A-1:0]     way_q;
  logic [S-1:0]     set_q;
  logic [2:0]       lvl_q;
  logic [1:0]       el_q;
  logic             e2_q, e3_q, sw_q, fg_q, fgt_q;
  logic [TAG_W-1:0] tag_q;
  logic             trap_q, undef_q;

  wire unused_bits = ^{req_operand[63:32], req_operand[31-A:L+S],
                       req_operand[L-1:4], req_operand[0]};

  wire trap_hit  = (el_q == 2'd1) && e2_q && (sw_q || (fg_q && (!e3_q || fgt_q)));
  wire undef_hit = (el_q == 2'd0);
  wire in_range  = (lvl_q == 3'(LEVEL_IMPL)) && (int'(way_q) < WAYS) &&
                   (int'(set_q) < SETS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      way_q   <= '0;
      set_q   <= '0;
      lvl_q   <= '0;
      el_q    <= '0;
      e2_q    <= 1'b0;
      e3_q    <= 1'b0;
      sw_q    <= 1'b0;
      fg_q    <= 1'b0;
      fgt_q   <= 1'b0;
      tag_q   <= '0;
      trap_q  <= 1'b0;
      undef_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          way_q   <= req_operand[31 -: A];
          set_q   <= req_operand[L +: S];
          lvl_q   <= req_operand[3:1];
          el_q    <= req_el;
          e2_q    <= el2_enabled;
          e3_q    <= el3_present;
          sw_q    <= hyp_sw_trap;
          fg_q    <= hyp_fg_trap;
          fgt_q   <= mon_fgt_en;
          trap_q  <= 1'b0;
          undef_q <= 1'b0;
          st      <= ST_DECODE;
        end
        ST_DECODE: begin
          trap_q  <= trap_hit;
          undef_q <= undef_hit;
          st      <= (trap_hit || undef_hit || !in_range) ? ST_DONE : ST_READ;
        end
        ST_READ: begin
          tag_q <= arr_rd_tag;
          st    <= (arr_rd_valid && arr_rd_dirty) ? ST_WB : ST_DONE;
        end
        ST_WB:   if (wb_ready) st <= ST_UPD;
        ST_UPD:  st <= ST_DONE;
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (st != ST_IDLE);
  assign done          = (st == ST_DONE);
  assign res_trap      = done && trap_q;
  assign res_undef     = done && undef_q;
  assign res_ec        = res_trap ? 6'h18 : 6'h00;
  assign arr_rd_en     = (st == ST_READ);
  assign arr_set       = set_q;
  assign arr_way       = way_q;
  assign arr_clr_dirty = (st == ST_UPD);
  assign wb_valid      = (st == ST_WB);
  assign wb_addr       = {tag_q, set_q, {L{1'b0}}};

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  p_wb_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr)));

  p_clr_after_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arr_clr_dirty |-> $past(wb_valid && wb_ready));

  p_read_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd_en |-> ((int'(arr_way) < WAYS) && (int'(arr_set) < SETS)));

  p_trap_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_trap || res_undef) |-> !$past(arr_rd_en));

endmodule

// File: tb/swclean_ctrl_tb.sv
module swclean_ctrl_tb;
  localparam int WAYS = 3, LINE_BYTES = 64, SETS = 48, TAG_W = 16, LVL = 1;
  localparam int A = 2, L = 6, S = 6, AW = TAG_W + S + L;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [63:0] req_operand = '0;
  logic [1:0] req_el = '0;
  logic el2_enabled = 0, el3_present = 0, hyp_sw_trap = 0, hyp_fg_trap = 0, mon_fgt_en = 0;
  logic busy, done, res_trap, res_undef, arr_rd_en, arr_clr_dirty, wb_valid;
  logic wb_ready = 0;
  logic [5:0] res_ec;
  logic [S-1:0] arr_set;
  logic [A-1:0] arr_way;
  logic [TAG_W-1:0] arr_rd_tag;
  logic arr_rd_valid, arr_rd_dirty;
  logic [AW-1:0] wb_addr;

  logic [TAG_W-1:0] mtag [64][4];
  logic mval [64][4];
  logic mdirty [64][4];

  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  assign arr_rd_tag   = mtag[arr_set][arr_way];
  assign arr_rd_valid = mval[arr_set][arr_way];
  assign arr_rd_dirty = mdirty[arr_set][arr_way];

  swclean_ctrl #(.WAYS(WAYS), .LINE_BYTES(LINE_BYTES), .SETS(SETS),
                 .TAG_W(TAG_W), .LEVEL_IMPL(LVL)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_operand(req_operand),
    .req_el(req_el), .el2_enabled(el2_enabled), .el3_present(el3_present),
    .hyp_sw_trap(hyp_sw_trap), .hyp_fg_trap(hyp_fg_trap), .mon_fgt_en(mon_fgt_en),
    .busy(busy), .done(done), .res_trap(res_trap), .res_undef(res_undef),
    .res_ec(res_ec), .arr_rd_en(arr_rd_en), .arr_set(arr_set), .arr_way(arr_way),
    .arr_rd_tag(arr_rd_tag), .arr_rd_valid(arr_rd_valid), .arr_rd_dirty(arr_rd_dirty),
    .arr_clr_dirty(arr_clr_dirty), .wb_valid(wb_valid), .wb_addr(wb_addr),
    .wb_ready(wb_ready));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_op(input int way, input int set, input int lvl);
    logic [63:0] op;
    op = {$urandom, $urandom};
    op[31:30] = 2'(way);
    op[11:6]  = 6'(set);
    op[3:1]   = 3'(lvl);
    return op;
  endfunction

  // kinds: 0 undef, 1 trap, 2 no-op, 3 clean/invalid line, 4 write-back
  function automatic int exp_kind(input logic [63:0] op, input logic [1:0] el,
                                  input bit e2, e3, sw, fg, fgt);
    int way, set, lvl;
    way = int'(op[31:30]); set = int'(op[11:6]); lvl = int'(op[3:1]);
    if (el == 2'd0) return 0;
    if (el == 2'd1 && e2 && (sw || (fg && (!e3 || fgt)))) return 1;
    if (lvl != LVL || way >= WAYS || set >= SETS) return 2;
    if (mval[set][way] && mdirty[set][way]) return 4;
    return 3;
  endfunction

  task automatic run_op(input logic [63:0] op, input logic [1:0] el,
                        input bit e2, e3, sw, fg, fgt, input int d, input string req);
    int k, way, set, rd_n, wb_n, clr_n, n;
    logic [S-1:0] seen_set;
    logic [A-1:0] seen_way;
    logic [AW-1:0] exp_addr, first_addr;
    bit addr_ok, rt, ru;
    logic [5:0] ec;
    way = int'(op[31:30]); set = int'(op[11:6]);
    k = exp_kind(op, el, e2, e3, sw, fg, fgt);
    exp_addr = (k == 4) ? {mtag[set][way], 6'(set), 6'b0} : '0;
    rd_n = 0; wb_n = 0; clr_n = 0; n = 0; addr_ok = 1;
    seen_set = '0; seen_way = '0; first_addr = '0; rt = 0; ru = 0; ec = '0;
    @(negedge clk);
    req_valid = 1; req_operand = op; req_el = el;
    el2_enabled = e2; el3_present = e3; hyp_sw_trap = sw; hyp_fg_trap = fg; mon_fgt_en = fgt;
    @(negedge clk);
    chk(busy === 1'b1, {req, " R10 busy after accept"}, longint'(busy), 1);
    forever begin
      req_valid = 1'($urandom);
      req_operand = {$urandom, $urandom};
      req_el = 2'($urandom);
      if (arr_rd_en) begin rd_n++; seen_set = arr_set; seen_way = arr_way; end
      if (wb_valid) begin
        wb_n++;
        if (wb_n == 1) first_addr = wb_addr;
        else if (wb_addr !== first_addr) addr_ok = 0;
        wb_ready = (wb_n >= d + 1);
      end else wb_ready = 0;
      if (arr_clr_dirty) begin
        clr_n++;
        mdirty[arr_set][arr_way] = 1'b0;
      end
      if (done) begin
        rt = res_trap; ru = res_undef; ec = res_ec;
        req_valid = 0;
        break;
      end
      n++;
      if (n > 60) break;
      @(negedge clk);
    end
    wb_ready = 0;
    chk(done === 1'b1, {req, " R10 done reached"}, longint'(done), 1);
    chk(rt == (k == 1) && ec == ((k == 1) ? 6'h18 : 6'h00), {req, " R5 R6 trap/ec"},
        longint'({rt, ec}), longint'({(k == 1), (k == 1) ? 6'h18 : 6'h00}));
    chk(ru == (k == 0), {req, " R7 undef"}, longint'(ru), longint'(k == 0));
    chk(rd_n == ((k >= 3) ? 1 : 0), {req, " R2 R4 R9 read count"}, rd_n, (k >= 3) ? 1 : 0);
    if (k >= 3)
      chk(seen_set == 6'(set) && seen_way == 2'(way), {req, " R1/R3 set/way"},
          longint'({seen_set, seen_way}), longint'({6'(set), 2'(way)}));
    chk(wb_n == ((k == 4) ? d + 1 : 0), {req, " R8 R9 wb cycles"}, wb_n, (k == 4) ? d + 1 : 0);
    chk(clr_n == ((k == 4) ? 1 : 0), {req, " R8 R9 clear count"}, clr_n, (k == 4) ? 1 : 0);
    if (k == 4)
      chk(addr_ok && first_addr == exp_addr, {req, " R8 wb address"}, longint'(first_addr),
          longint'(exp_addr));
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, {req, " R10 idle after done"},
        longint'({busy, done}), 0);
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int s = 0; s < 64; s++)
      for (int w = 0; w < 4; w++) begin
        mtag[s][w] = 16'($urandom);
        mval[s][w] = 1'($urandom);
        mdirty[s][w] = 1'($urandom);
      end
    repeat (3) @(negedge clk);
    chk(busy === 0 && done === 0 && wb_valid === 0 && arr_rd_en === 0 && arr_clr_dirty === 0,
        "R10 reset state", longint'({busy, done, wb_valid, arr_rd_en}), 0);
    rst_n = 1;
    @(negedge clk);

    mval[5][2] = 1; mdirty[5][2] = 1;
    run_op(mk_op(2, 5, LVL), 2'd3, 1, 1, 1, 1, 1, 0, "dir R8 dirty EL3");
    run_op(mk_op(2, 5, LVL), 2'd3, 0, 0, 0, 0, 0, 0, "dir R9 now clean");
    mval[7][1] = 1; mdirty[7][1] = 1;
    run_op(mk_op(1, 7, LVL), 2'd1, 1, 0, 1, 0, 0, 0, "dir R5 sw trap");
    run_op(mk_op(1, 7, LVL), 2'd1, 0, 0, 1, 1, 1, 0, "dir R5 no el2");
    mdirty[7][1] = 1;
    run_op(mk_op(1, 7, LVL), 2'd1, 1, 1, 0, 1, 0, 2, "dir R6 fg blocked by monitor");
    run_op(mk_op(1, 7, LVL), 2'd1, 1, 0, 0, 1, 0, 0, "dir R6 fg no monitor");
    run_op(mk_op(1, 7, LVL), 2'd1, 1, 1, 0, 1, 1, 0, "dir R6 fg monitor enabled");
    run_op(mk_op(0, 3, LVL), 2'd0, 0, 0, 0, 0, 0, 0, "dir R7 el0 undef");
    mdirty[3][0] = 1; mval[3][0] = 1;
    run_op(mk_op(0, 3, LVL), 2'd2, 1, 1, 1, 1, 1, 0, "dir R7 el2 ignores traps");
    run_op(mk_op(3, 4, LVL), 2'd3, 0, 0, 0, 0, 0, 0, "dir R4 way out of range");
    run_op(mk_op(0, 50, LVL), 2'd3, 0, 0, 0, 0, 0, 0, "dir R4 set out of range");
    run_op(mk_op(0, 4, 0), 2'd3, 0, 0, 0, 0, 0, 0, "dir R2 other level");
    mval[9][1] = 0; mdirty[9][1] = 1;
    run_op(mk_op(1, 9, LVL), 2'd3, 0, 0, 0, 0, 0, 0, "dir R9 invalid dirty");
    mval[10][2] = 1; mdirty[10][2] = 1;
    run_op(mk_op(2, 10, LVL), 2'd2, 0, 0, 0, 0, 0, 3, "dir R8 ready delayed");

    for (int i = 0; i < 300; i++) begin
      int w, s, lv;
      w = int'($urandom % 4);
      s = int'($urandom % 64);
      lv = ($urandom % 4 == 0) ? int'($urandom % 8) : LVL;
      if (w < 4 && s < 64 && ($urandom % 2)) mdirty[s][w] = 1;
      run_op(mk_op(w, s, lv), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             1'($urandom), 1'($urandom), int'($urandom % 4), "rnd R1");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule